// File: doc/BRIEF.md
# CAN Receive Acceptance and Double Buffering

This block sits after a CAN bit-level receiver. When a frame has been fully assembled, the receiver presents the identifier, the frame-type flags, the length code and eight data bytes, and pulses an end-of-frame strobe. The block then decides which of two receive slots takes the frame, if either does. The decision uses a per-slot mask and a set of acceptance filters, and it follows a per-slot receive mode.

Slot 0 has priority and is evaluated first, with two filters. Slot 1 has four filters. A slot that has been loaded stays locked until the host releases it. An optional rollover sends frames that slot 0 accepts into slot 1 while slot 0 is locked. A frame that cannot be stored sets an overflow flag. Each slot shows its stored frame, the number of the filter that admitted it, and its full and overflow flags.

Top module: `can_rx_accept`

## Requirements
- R1: After reset both full flags and both overflow flags are 0. Every stored field reads 0 and both filter-number outputs read 7.
- R2: A filter matches when its extended-select bit equals the frame's IDE bit and ((id XOR filter) AND mask) is zero. The comparison covers all 29 bits for extended frames and only id[10:0] for standard frames. A mask bit of 0 makes that identifier bit a don't-care.
- R3: Filters are numbered 0–1 for slot 0 and 2–5 for slot 1, in the order they sit in `flt_id`/`flt_ext`. When several filters in a slot match, the lowest number is reported. The code 7 means the frame was taken without a filter.
- R4: Slot 0 is evaluated first. A frame that slot 0 accepts is never loaded into slot 1 through slot 1's own filters, and at most one slot is loaded per frame.
- R5: Each slot has a 2-bit mode. 0 accepts through the filters only. 1 is the same but accepts standard frames (IDE=0) only. 2 is the same but accepts extended frames (IDE=1) only. 3 accepts every frame and reports filter number 7.
- R6: On acceptance the slot copies the whole assembled frame: id, IDE, RTR, DLC and all 64 data bits, including bytes beyond the DLC.
- R7: Loading a slot sets its full flag. While the flag is set, the slot's contents do not change.
- R8: If a frame is accepted for a locked slot and no rollover applies, the frame is dropped and that slot's overflow flag is set. If a frame rolls over into a locked slot 1, the overflow flag of slot 1 is set.
- R9: With `rollover_en`=1, a frame that slot 0 accepts while slot 0 is locked goes into slot 1. This happens whatever slot 1's filters and mode say, and slot 1 reports slot 0's filter number.
- R10: `release_buf[b]` clears the full and overflow flags of slot b. A release in the same cycle as a strobe frees the slot before that frame is placed.
- R11: Results appear on the first rising clock edge at which `asm_valid` is sampled high. Outputs do not change before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| asm_valid | input | 1 | End-of-frame strobe, one cycle per assembled frame |
| asm_id | input | 29 | Identifier; standard frames use bits [10:0] |
| asm_ide | input | 1 | 1 = extended frame |
| asm_rtr | input | 1 | 1 = remote frame |
| asm_dlc | input | 4 | Data length code |
| asm_data | input | 64 | Eight data bytes |
| mask0 | input | 29 | Mask of slot 0 |
| mask1 | input | 29 | Mask of slot 1 |
| flt_id | input | 174 | Six 29-bit filter values, filter n at bits [29n+28:29n] |
| flt_ext | input | 6 | Extended-select bit of each filter |
| mode0 | input | 2 | Receive mode of slot 0 |
| mode1 | input | 2 | Receive mode of slot 1 |
| rollover_en | input | 1 | Enables rollover from slot 0 to slot 1 |
| release_buf | input | 2 | Host release of slot 1/slot 0 |
| b0_id | output | 29 | Slot 0 identifier |
| b0_ide | output | 1 | Slot 0 extended flag |
| b0_rtr | output | 1 | Slot 0 remote flag |
| b0_dlc | output | 4 | Slot 0 length code |
| b0_data | output | 64 | Slot 0 data |
| b0_hit | output | 3 | Slot 0 admitting filter number |
| b1_id | output | 29 | Slot 1 identifier |
| b1_ide | output | 1 | Slot 1 extended flag |
| b1_rtr | output | 1 | Slot 1 remote flag |
| b1_dlc | output | 4 | Slot 1 length code |
| b1_data | output | 64 | Slot 1 data |
| b1_hit | output | 3 | Slot 1 admitting filter number |
| buf_full | output | 2 | Full (locked) flags, bit b for slot b |
| buf_ovf | output | 2 | Overflow flags, bit b for slot b |

## Verification
Every result of this block comes from a single register stage. Stored frames, filter numbers, full flags and overflow flags all change on the edge that samples the strobe or the release, and not before. The bench drives each frame and release on a falling edge. One time unit later, before the rising edge, it confirms the flags are still unchanged. It then compares every output against its own model at the following falling edge, one full clock after the stimulus. The model advances exactly once per driven cycle, so expected and actual state stay aligned through both directed and random sequences.

// File: rtl/can_rx_pkg.sv
package can_rx_pkg;

   localparam int ID_W   = 29;
   localparam int STD_W  = 11;
   localparam int DLC_W  = 4;
   localparam int DATA_W = 64;

   typedef enum logic [1:0] {
      RXM_FILT = 2'b00,
      RXM_STD  = 2'b01,
      RXM_EXT  = 2'b10,
      RXM_ALL  = 2'b11
   } rx_mode_e;

   typedef struct packed {
      logic [ID_W-1:0]   id;
      logic              ide;
      logic              rtr;
      logic [DLC_W-1:0]  dlc;
      logic [DATA_W-1:0] data;
   } rx_frame_t;

endpackage

// File: rtl/can_rx_fbank.sv
module can_rx_fbank
   import can_rx_pkg::*;
#(
   parameter int NF    = 2,
   parameter int BASE  = 0,
   parameter int HIT_W = 3
) (
   input  logic [ID_W-1:0]    id,
   input  logic               ide,
   input  logic [ID_W-1:0]    mask,
   input  logic [NF*ID_W-1:0] fid,
   input  logic [NF-1:0]      fext,
   input  logic [1:0]         mode,
   output logic               accept,
   output logic [HIT_W-1:0]   hit
);
   localparam logic [HIT_W-1:0] NONE_HIT = '1;

   logic [ID_W-1:0] cmp_mask;
   logic [NF-1:0]   fmatch;
   logic            found;
   logic [HIT_W-1:0] first;

   initial begin
      if (BASE + NF > (1 << HIT_W) - 1)
         $error("filter numbers collide with the no-filter code");
   end

   assign cmp_mask = ide ? mask : {{(ID_W-STD_W){1'b0}}, mask[STD_W-1:0]};

   for (genvar f = 0; f < NF; f++) begin : g_flt
      assign fmatch[f] = (fext[f] == ide) &&
                         (((id ^ fid[f*ID_W +: ID_W]) & cmp_mask) == '0);
   end

   always_comb begin
      found = 1'b0;
      first = NONE_HIT;
      for (int i = NF - 1; i >= 0; i--) begin
         if (fmatch[i]) begin
            found = 1'b1;
            first = HIT_W'(BASE + i);
         end
      end
   end

   always_comb begin
      accept = 1'b0;
      hit    = first;
      case (rx_mode_e'(mode))
         RXM_ALL: begin
            accept = 1'b1;
            hit    = NONE_HIT;
         end
         RXM_STD:  accept = found && !ide;
         RXM_EXT:  accept = found && ide;
         default:  accept = found;
      endcase
   end

endmodule

// File: rtl/can_rx_route.sv
module can_rx_route #(
   parameter int HIT_W = 3
) (
   input  logic             valid,
   input  logic [1:0]       acc,
   input  logic [HIT_W-1:0] hit0,
   input  logic [HIT_W-1:0] hit1,
   input  logic [1:0]       busy,
   input  logic             roll_en,
   output logic [1:0]       load,
   output logic [HIT_W-1:0] hit_sel0,
   output logic [HIT_W-1:0] hit_sel1,
   output logic [1:0]       ovf_set
);
   always_comb begin
      load     = 2'b00;
      ovf_set  = 2'b00;
      hit_sel0 = hit0;
      hit_sel1 = hit1;
      if (valid) begin
         if (acc[0]) begin
            if (!busy[0]) begin
               load[0] = 1'b1;
            end else if (roll_en) begin
               hit_sel1 = hit0;
               if (!busy[1]) load[1]    = 1'b1;
               else          ovf_set[1] = 1'b1;
            end else begin
               ovf_set[0] = 1'b1;
            end
         end else if (acc[1]) begin
            if (!busy[1]) load[1]    = 1'b1;
            else          ovf_set[1] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/can_rx_slot.sv
module can_rx_slot
   import can_rx_pkg::*;
#(
   parameter int HIT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  rx_frame_t        frame_in,
   input  logic [HIT_W-1:0] hit_in,
   input  logic             ovf_set,
   input  logic             release_i,
   output rx_frame_t        frame_q,
   output logic [HIT_W-1:0] hit_q,
   output logic             full_q,
   output logic             ovf_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame_q <= '0;
         hit_q   <= '1;
         full_q  <= 1'b0;
         ovf_q   <= 1'b0;
      end else begin
         if (load) begin
            frame_q <= frame_in;
            hit_q   <= hit_in;
         end
         if (load)           full_q <= 1'b1;
         else if (release_i) full_q <= 1'b0;
         if (ovf_set)        ovf_q  <= 1'b1;
         else if (release_i) ovf_q  <= 1'b0;
      end
   end
endmodule

// File: rtl/can_rx_accept.sv
module can_rx_accept
   import can_rx_pkg::*;
#(
   parameter  int NF0    = 2,
   parameter  int NF1    = 4,
   localparam int NF_TOT = NF0 + NF1,
   localparam int HIT_W  = $clog2(NF_TOT + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   asm_valid,
   input  logic [ID_W-1:0]        asm_id,
   input  logic                   asm_ide,
   input  logic                   asm_rtr,
   input  logic [DLC_W-1:0]       asm_dlc,
   input  logic [DATA_W-1:0]      asm_data,
   input  logic [ID_W-1:0]        mask0,
   input  logic [ID_W-1:0]        mask1,
   input  logic [NF_TOT*ID_W-1:0] flt_id,
   input  logic [NF_TOT-1:0]      flt_ext,
   input  logic [1:0]             mode0,
   input  logic [1:0]             mode1,
   input  logic                   rollover_en,
   input  logic [1:0]             release_buf,
   output logic [ID_W-1:0]        b0_id,
   output logic                   b0_ide,
   output logic                   b0_rtr,
   output logic [DLC_W-1:0]       b0_dlc,
   output logic [DATA_W-1:0]      b0_data,
   output logic [HIT_W-1:0]       b0_hit,
   output logic [ID_W-1:0]        b1_id,
   output logic                   b1_ide,
   output logic                   b1_rtr,
   output logic [DLC_W-1:0]       b1_dlc,
   output logic [DATA_W-1:0]      b1_data,
   output logic [HIT_W-1:0]       b1_hit,
   output logic [1:0]             buf_full,
   output logic [1:0]             buf_ovf
);
   initial begin
      if (NF0 < 1 || NF1 < 1) $error("each slot needs at least one filter");
      if (DATA_W % 8 != 0)    $error("data width must be whole bytes");
      if (STD_W > ID_W)       $error("standard id wider than identifier");
   end

   rx_frame_t        asm_frame;
   logic [1:0]       bank_acc;
   logic [HIT_W-1:0] bank_hit [2];
   logic [1:0]       busy;
   logic [1:0]       load;
   logic [1:0]       ovf_set;
   logic [HIT_W-1:0] slot_hit_in [2];
   rx_frame_t        slot_frame [2];
   logic [HIT_W-1:0] slot_hit [2];

   always_comb begin
      asm_frame.id   = asm_id;
      asm_frame.ide  = asm_ide;
      asm_frame.rtr  = asm_rtr;
      asm_frame.dlc  = asm_dlc;
      asm_frame.data = asm_data;
   end

   for (genvar b = 0; b < 2; b++) begin : g_bank
      localparam int NF_B   = (b == 0) ? NF0 : NF1;
      localparam int BASE_B = (b == 0) ? 0 : NF0;
      can_rx_fbank #(
         .NF    (NF_B),
         .BASE  (BASE_B),
         .HIT_W (HIT_W)
      ) u_bank (
         .id     (asm_id),
         .ide    (asm_ide),
         .mask   ((b == 0) ? mask0 : mask1),
         .fid    (flt_id[BASE_B*ID_W +: NF_B*ID_W]),
         .fext   (flt_ext[BASE_B +: NF_B]),
         .mode   ((b == 0) ? mode0 : mode1),
         .accept (bank_acc[b]),
         .hit    (bank_hit[b])
      );
   end

   assign busy = buf_full & ~release_buf;

   can_rx_route #(.HIT_W(HIT_W)) u_route (
      .valid    (asm_valid),
      .acc      (bank_acc),
      .hit0     (bank_hit[0]),
      .hit1     (bank_hit[1]),
      .busy     (busy),
      .roll_en  (rollover_en),
      .load     (load),
      .hit_sel0 (slot_hit_in[0]),
      .hit_sel1 (slot_hit_in[1]),
      .ovf_set  (ovf_set)
   );

   for (genvar b = 0; b < 2; b++) begin : g_slot
      can_rx_slot #(.HIT_W(HIT_W)) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .load      (load[b]),
         .frame_in  (asm_frame),
         .hit_in    (slot_hit_in[b]),
         .ovf_set   (ovf_set[b]),
         .release_i (release_buf[b]),
         .frame_q   (slot_frame[b]),
         .hit_q     (slot_hit[b]),
         .full_q    (buf_full[b]),
         .ovf_q     (buf_ovf[b])
      );
   end

   assign b0_id   = slot_frame[0].id;
   assign b0_ide  = slot_frame[0].ide;
   assign b0_rtr  = slot_frame[0].rtr;
   assign b0_dlc  = slot_frame[0].dlc;
   assign b0_data = slot_frame[0].data;
   assign b0_hit  = slot_hit[0];
   assign b1_id   = slot_frame[1].id;
   assign b1_ide  = slot_frame[1].ide;
   assign b1_rtr  = slot_frame[1].rtr;
   assign b1_dlc  = slot_frame[1].dlc;
   assign b1_data = slot_frame[1].data;
   assign b1_hit  = slot_hit[1];

endmodule

// File: rtl/can_rx_accept_chk.sv
module can_rx_accept_chk #(
   parameter int NF0   = 2,
   parameter int HIT_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             asm_valid,
   input logic [1:0]       mode0,
   input logic [1:0]       release_buf,
   input logic [28:0]      b0_id,
   input logic [63:0]      b0_data,
   input logic [HIT_W-1:0] b0_hit,
   input logic [28:0]      b1_id,
   input logic [63:0]      b1_data,
   input logic [1:0]       buf_full,
   input logic [1:0]       buf_ovf
);
   localparam logic [HIT_W-1:0] NONE_HIT = '1;

   AST_ALL_MODE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      asm_valid && mode0 == 2'b11 && !(buf_full[0] && !release_buf[0]) |=> buf_full[0]); // R5

   AST_LOCK_HOLD0: assert property (@(posedge clk) disable iff (!rst_n)
      buf_full[0] && !release_buf[0] |=> $stable(b0_id) && $stable(b0_data)); // R7

   AST_LOCK_HOLD1: assert property (@(posedge clk) disable iff (!rst_n)
      buf_full[1] && !release_buf[1] |=> $stable(b1_id) && $stable(b1_data)); // R7

   AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      !($rose(buf_full[0]) && $rose(buf_full[1]))); // R4

   AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(buf_ovf[0]) || $rose(buf_ovf[1]) |-> $past(asm_valid)); // R8

   AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      release_buf[1] && !asm_valid |=> !buf_full[1] && !buf_ovf[1]); // R10

   AST_B0_HIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      buf_full[0] |-> (b0_hit < HIT_W'(NF0)) || (b0_hit == NONE_HIT)); // R3

endmodule

bind can_rx_accept can_rx_accept_chk #(.NF0(NF0), .HIT_W(HIT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .asm_valid   (asm_valid),
   .mode0       (mode0),
   .release_buf (release_buf),
   .b0_id       (b0_id),
   .b0_data     (b0_data),
   .b0_hit      (b0_hit),
   .b1_id       (b1_id),
   .b1_data     (b1_data),
   .buf_full    (buf_full),
   .buf_ovf     (buf_ovf)
);

// File: tb/can_rx_accept_tb.sv
`timescale 1ns/1ps
module can_rx_accept_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic        asm_valid = 1'b0;
   logic [28:0] asm_id = '0;
   logic        asm_ide = 1'b0, asm_rtr = 1'b0;
   logic [3:0]  asm_dlc = '0;
   logic [63:0] asm_data = '0;
   logic [1:0]  release_buf = '0;
   logic        rollover_en = 1'b0;
   logic [28:0] cfg_mask [2];
   logic [28:0] cfg_fid  [6];
   logic [5:0]  cfg_fext;
   logic [1:0]  cfg_mode [2];
   logic [173:0] flt_id;

   always_comb for (int i = 0; i < 6; i++) flt_id[i*29 +: 29] = cfg_fid[i];

   logic [28:0] b0_id, b1_id;
   logic        b0_ide, b0_rtr, b1_ide, b1_rtr;
   logic [3:0]  b0_dlc, b1_dlc;
   logic [63:0] b0_data, b1_data;
   logic [2:0]  b0_hit, b1_hit;
   logic [1:0]  buf_full, buf_ovf;

   can_rx_accept u_dut (
      .clk(clk), .rst_n(rst_n), .asm_valid(asm_valid), .asm_id(asm_id),
      .asm_ide(asm_ide), .asm_rtr(asm_rtr), .asm_dlc(asm_dlc), .asm_data(asm_data),
      .mask0(cfg_mask[0]), .mask1(cfg_mask[1]), .flt_id(flt_id), .flt_ext(cfg_fext),
      .mode0(cfg_mode[0]), .mode1(cfg_mode[1]), .rollover_en(rollover_en),
      .release_buf(release_buf),
      .b0_id(b0_id), .b0_ide(b0_ide), .b0_rtr(b0_rtr), .b0_dlc(b0_dlc),
      .b0_data(b0_data), .b0_hit(b0_hit),
      .b1_id(b1_id), .b1_ide(b1_ide), .b1_rtr(b1_rtr), .b1_dlc(b1_dlc),
      .b1_data(b1_data), .b1_hit(b1_hit),
      .buf_full(buf_full), .buf_ovf(buf_ovf)
   );

   int checks = 0, fails = 0;
   bit done = 1'b0;

   logic [1:0]   e_full = '0, e_ovf = '0;
   logic [101:0] e_slot [2];

   function automatic logic [3:0] bank_eval(input int b, input logic [28:0] id, input logic ide);
      int lo = (b == 0) ? 0 : 2;
      int n  = (b == 0) ? 2 : 4;
      logic [28:0] cm = ide ? cfg_mask[b] : (cfg_mask[b] & 29'h7FF);
      if (cfg_mode[b] == 2'd3) return {1'b1, 3'd7};
      if (cfg_mode[b] == 2'd1 && ide)  return {1'b0, 3'd7};
      if (cfg_mode[b] == 2'd2 && !ide) return {1'b0, 3'd7};
      for (int i = lo; i < lo + n; i++)
         if (cfg_fext[i] == ide && ((id ^ cfg_fid[i]) & cm) == '0) return {1'b1, 3'(i)};
      return {1'b0, 3'd7};
   endfunction

   task automatic chk(input string tag, input string what, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      chk(tag, "flags", {124'd0, buf_full, buf_ovf}, {124'd0, e_full, e_ovf});
      chk(tag, "slot0", {26'd0, b0_id, b0_ide, b0_rtr, b0_dlc, b0_data, b0_hit}, {26'd0, e_slot[0]});
      chk(tag, "slot1", {26'd0, b1_id, b1_ide, b1_rtr, b1_dlc, b1_data, b1_hit}, {26'd0, e_slot[1]});
   endtask

   task automatic load_exp(input int b, input logic [2:0] hit);
      e_full[b] = 1'b1;
      e_slot[b] = {asm_id, asm_ide, asm_rtr, asm_dlc, asm_data, hit};
   endtask

   // one cycle: drive at falling edge, check R11 before the rising edge, check all one clock later
   task automatic txn(input string tag, input logic v, input logic [28:0] id, input logic ide,
                      input logic rtr, input logic [3:0] dlc, input logic [63:0] data,
                      input logic [1:0] rel);
      logic [1:0] busy;
      logic [3:0] r0, r1;
      asm_valid = v; asm_id = id; asm_ide = ide; asm_rtr = rtr; asm_dlc = dlc;
      asm_data = data; release_buf = rel;
      #1;
      chk("R11", "pre-edge flags", {124'd0, buf_full, buf_ovf}, {124'd0, e_full, e_ovf});
      busy = e_full & ~rel;
      for (int b = 0; b < 2; b++) if (rel[b]) begin e_full[b] = 1'b0; e_ovf[b] = 1'b0; end
      if (v) begin
         r0 = bank_eval(0, id, ide);
         r1 = bank_eval(1, id, ide);
         if (r0[3]) begin
            if (!busy[0]) load_exp(0, r0[2:0]);
            else if (rollover_en) begin
               if (!busy[1]) load_exp(1, r0[2:0]);
               else e_ovf[1] = 1'b1;
            end else e_ovf[0] = 1'b1;
         end else if (r1[3]) begin
            if (!busy[1]) load_exp(1, r1[2:0]);
            else e_ovf[1] = 1'b1;
         end
      end
      @(negedge clk);
      check_all(tag);
      asm_valid = 1'b0; release_buf = '0;
   endtask

   function automatic logic [28:0] pick_id();
      case ($urandom % 5)
         0: return 29'h123;
         1: return 29'h2A0;
         2: return 29'h1ABCDE;
         3: return 29'h0ABCD00;
         default: return 29'($urandom);
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      cfg_mask[0] = '1;               cfg_mask[1] = 29'h1FFFFFF0;
      cfg_fid[0] = 29'h123;           cfg_fid[1] = 29'h1ABCDE;
      cfg_fid[2] = 29'h2A0;           cfg_fid[3] = 29'h555;
      cfg_fid[4] = 29'h0ABCD00;       cfg_fid[5] = 29'h7FF;
      cfg_fext = 6'b010010;
      cfg_mode[0] = 2'd0; cfg_mode[1] = 2'd0;
      e_slot[0] = {99'd0, 3'd7}; e_slot[1] = {99'd0, 3'd7};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1");
      // directed corners
      txn("R2 R3", 1, 29'h123, 0, 0, 4'd1, 64'h11, 2'b00);
      txn("R2 R10", 1, 29'h2A5, 0, 1, 4'd0, 64'h22, 2'b01);
      txn("R2 ext-select conflict", 1, 29'h123, 1, 0, 4'd2, 64'h33, 2'b00);
      txn("R3 ext", 1, 29'h1ABCDE, 1, 0, 4'd8, 64'h0102030405060708, 2'b00);
      txn("R7 R8 locked", 1, 29'h123, 0, 0, 4'd3, 64'h44, 2'b00);
      rollover_en = 1'b1;
      txn("R9 R10 rollover", 1, 29'h123, 0, 1, 4'd4, 64'h55, 2'b10);
      txn("R8 rollover into locked", 1, 29'h123, 0, 0, 4'd5, 64'h66, 2'b00);
      rollover_en = 1'b0;
      cfg_mode[0] = 2'd3;
      txn("R5 R6 accept-all", 1, 29'h0BADBAD, 1, 1, 4'd2, 64'hDEADBEEFCAFEF00D, 2'b11);
      txn("R4 slot0 first", 1, 29'h2A0, 0, 0, 4'd1, 64'h77, 2'b00);
      cfg_mode[0] = 2'd1; cfg_mode[1] = 2'd2;
      txn("R5 std-only rejects ext", 1, 29'h1ABCDE, 1, 0, 4'd1, 64'h88, 2'b11);
      txn("R5 ext-only filter", 1, 29'h0ABCD07, 1, 0, 4'd1, 64'h99, 2'b00);
      txn("R5 ext-only rejects std", 1, 29'h2A0, 0, 0, 4'd1, 64'hAA, 2'b10);
      cfg_mode[0] = 2'd0; cfg_mode[1] = 2'd3;
      txn("R4 one slot", 1, 29'h123, 0, 0, 4'd6, 64'hBB, 2'b11);
      cfg_mask[0] = '0;
      txn("R2 zero mask", 1, 29'h7AB, 0, 0, 4'd0, 64'hCC, 2'b01);
      txn("R10 release only", 0, 29'h0, 0, 0, 4'd0, 64'h0, 2'b11);
      // constrained random
      for (int n = 0; n < 600; n++) begin
         if (n % 50 == 0) begin
            for (int b = 0; b < 2; b++) begin
               case ($urandom % 4)
                  0: cfg_mask[b] = '1;
                  1: cfg_mask[b] = 29'h1FFFFFF0;
                  2: cfg_mask[b] = '0;
                  default: cfg_mask[b] = 29'($urandom);
               endcase
               cfg_mode[b] = ($urandom % 6 == 0) ? 2'd3 : 2'($urandom % 3);
            end
            for (int f = 0; f < 6; f++) cfg_fid[f] = pick_id();
            cfg_fext = 6'($urandom);
            rollover_en = 1'($urandom);
         end
         txn("RND", 1'($urandom % 4 != 0), pick_id() ^ 29'($urandom % 4), 1'($urandom),
             1'($urandom), 4'($urandom % 9), {$urandom, $urandom},
             ($urandom % 4 == 0) ? 2'($urandom) : 2'b00);
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule